// File: doc/BRIEF.md
# Supply Switchover and Event Timestamp Controller

This block chooses whether a timekeeping device runs from its main supply or from its backup battery. Every clock cycle it samples two unsigned 12-bit millivolt codes, one for the main rail and one for the battery. It moves to battery only when the main rail is both under the battery level less a hysteresis margin and under a fixed trip level. It returns to main supply when the main rail rises above the battery level plus the same margin, or above the trip level plus a second, smaller margin.

While on battery, the block drops the enable for the serial host interface buffers. The rest of the timekeeping logic keeps running. Each mode change raises a one-cycle pulse and stores the current time value in one of two timestamp registers. The power-down register keeps the first power-down seen since the last status read. The power-up register always takes the most recent power-up. A one-cycle status-read strobe re-arms power-down capture.

Top module: `pwr_switchover`

## Requirements
- R1: In main mode the block moves to battery mode at a clock edge where vdd_mv < (bat_mv − 50, saturated at 0) and vdd_mv < 2200 both hold. The outputs show the change right after that edge. In main mode it otherwise stays in main mode.
- R2: In battery mode the block moves to main mode at a clock edge where vdd_mv > bat_mv + 50 or vdd_mv > 2230. Otherwise it stays in battery mode.
- R3: on_battery is 1 in battery mode and 0 in main mode. host_if_en is always the inverse of on_battery.
- R4: At every battery-to-main edge, stamp_up loads the now_time value sampled at that edge.
- R5: At a main-to-battery edge, stamp_down loads now_time only if no power-down has been captured since reset or since the last status read. Otherwise stamp_down keeps its value.
- R6: A status_rd pulse re-arms power-down capture. A status_rd that arrives on the same edge as a power-down counts as already re-armed, so that power-down is captured.
- R7: When bat_mv is below 50, the battery limit for R1 is 0 and does not wrap, so no voltage causes a power-down.
- R8: mode_change is high for exactly the one cycle after each edge where the mode changes, and is low otherwise.
- R9: Reset is synchronous and active high. After reset the block is in main mode with host_if_en=1, mode_change=0, both stamps at 0 and power-down capture armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_mv | input | 12 | Main rail voltage, millivolts |
| bat_mv | input | 12 | Battery voltage, millivolts |
| now_time | input | 32 | Current time value |
| status_rd | input | 1 | One-cycle status-read strobe |
| on_battery | output | 1 | 1 while running from battery |
| host_if_en | output | 1 | Serial host interface enable |
| mode_change | output | 1 | One-cycle pulse on each mode change |
| stamp_down | output | 32 | Time of the captured power-down |
| stamp_up | output | 32 | Time of the latest power-up |

## Verification
The assertions check four things on every cycle: each mode holds while its exit condition is false, the host enable stays opposite to the mode flag, the pulse coincides with a real mode change, and power-up capture loads the sampled time. A held power-down stamp must stay stable while capture is disarmed. Only the bench scenarios can show the exact threshold boundaries (equal values, the saturated battery limit) and the earliest-kept policy across several outages. They also cover a status read that coincides with a power-down, checked against an independent model under random voltages.

// File: rtl/pwr_sw_pkg.sv
package pwr_sw_pkg;
  typedef enum logic {
    SUP_MAIN = 1'b0,
    SUP_BATT = 1'b1
  } supply_t;
endpackage

// File: rtl/pwr_sw_thresh.sv
module pwr_sw_thresh #(
  parameter int VW          = 12,
  parameter int HYS_MV      = 50,
  parameter int TRIP_MV     = 2200,
  parameter int TRIP_HYS_MV = 30
) (
  input  logic [VW-1:0] vdd_mv,
  input  logic [VW-1:0] bat_mv,
  output logic          drop_ok,
  output logic          rise_ok
);
  localparam int EW = VW + 1;
  localparam logic [VW-1:0] HYS_V   = VW'(HYS_MV);
  localparam logic [EW-1:0] TRIP_LO = EW'(TRIP_MV);
  localparam logic [EW-1:0] TRIP_HI = EW'(TRIP_MV + TRIP_HYS_MV);

  logic [VW-1:0] bat_lo;
  logic [EW-1:0] bat_hi;
  logic [EW-1:0] vdd_x;

  always_comb begin
    // saturating subtract keeps a low battery reading from wrapping
    bat_lo = (bat_mv > HYS_V) ? (bat_mv - HYS_V) : '0;
    bat_hi = {1'b0, bat_mv} + EW'(HYS_MV);
    vdd_x  = {1'b0, vdd_mv};
    drop_ok = (vdd_mv < bat_lo) && (vdd_x < TRIP_LO);
    rise_ok = (vdd_x > bat_hi) || (vdd_x > TRIP_HI);
  end
endmodule

// File: rtl/pwr_sw_mode.sv
module pwr_sw_mode
  import pwr_sw_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    drop_ok,
  input  logic    rise_ok,
  output supply_t mode_q,
  output logic    host_en_q,
  output logic    chg_q,
  output logic    go_down,
  output logic    go_up
);
  always_comb begin
    go_down = (mode_q == SUP_MAIN) && drop_ok;
    go_up   = (mode_q == SUP_BATT) && rise_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= SUP_MAIN;
      host_en_q <= 1'b1;
      chg_q     <= 1'b0;
    end else begin
      chg_q <= go_down | go_up;
      if (go_down) begin
        mode_q    <= SUP_BATT;
        host_en_q <= 1'b0;
      end else if (go_up) begin
        mode_q    <= SUP_MAIN;
        host_en_q <= 1'b1;
      end
    end
  end

  p_stay_main_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SUP_MAIN && !drop_ok) |=> (mode_q == SUP_MAIN));
  p_stay_batt_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SUP_BATT && !rise_ok) |=> (mode_q == SUP_BATT));
  p_cond_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(drop_ok && rise_ok));
endmodule

// File: rtl/pwr_sw_stamp.sv
module pwr_sw_stamp #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_down,
  input  logic          go_up,
  input  logic          status_rd,
  input  logic [TW-1:0] now_time,
  output logic [TW-1:0] stamp_down,
  output logic [TW-1:0] stamp_up
);
  logic held_q;
  logic held_eff;

  always_comb held_eff = held_q & ~status_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q     <= 1'b0;
      stamp_down <= '0;
      stamp_up   <= '0;
    end else begin
      if (go_down) begin
        if (!held_eff) stamp_down <= now_time;
        held_q <= 1'b1;
      end else begin
        held_q <= held_eff;
      end
      if (go_up) stamp_up <= now_time;
    end
  end

  p_up_capture_r4: assert property (@(posedge clk) disable iff (rst)
    go_up |=> (stamp_up == $past(now_time)));
  p_keep_first_r5: assert property (@(posedge clk) disable iff (rst)
    (go_down && held_q && !status_rd) |=> $stable(stamp_down));
  p_rearm_r6: assert property (@(posedge clk) disable iff (rst)
    (go_down && status_rd) |=> (stamp_down == $past(now_time)));
endmodule

// File: rtl/pwr_switchover.sv
module pwr_switchover
  import pwr_sw_pkg::*;
#(
  parameter int VW          = 12,
  parameter int TW          = 32,
  parameter int HYS_MV      = 50,
  parameter int TRIP_MV     = 2200,
  parameter int TRIP_HYS_MV = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] vdd_mv,
  input  logic [VW-1:0] bat_mv,
  input  logic [TW-1:0] now_time,
  input  logic          status_rd,
  output logic          on_battery,
  output logic          host_if_en,
  output logic          mode_change,
  output logic [TW-1:0] stamp_down,
  output logic [TW-1:0] stamp_up
);
  logic    drop_ok, rise_ok, go_down, go_up;
  supply_t mode_q;

  pwr_sw_thresh #(
    .VW(VW), .HYS_MV(HYS_MV), .TRIP_MV(TRIP_MV), .TRIP_HYS_MV(TRIP_HYS_MV)
  ) u_thresh (
    .vdd_mv(vdd_mv), .bat_mv(bat_mv), .drop_ok(drop_ok), .rise_ok(rise_ok)
  );

  pwr_sw_mode u_mode (
    .clk(clk), .rst(rst), .drop_ok(drop_ok), .rise_ok(rise_ok),
    .mode_q(mode_q), .host_en_q(host_if_en), .chg_q(mode_change),
    .go_down(go_down), .go_up(go_up)
  );

  pwr_sw_stamp #(.TW(TW)) u_stamp (
    .clk(clk), .rst(rst), .go_down(go_down), .go_up(go_up),
    .status_rd(status_rd), .now_time(now_time),
    .stamp_down(stamp_down), .stamp_up(stamp_up)
  );

  assign on_battery = (mode_q == SUP_BATT);

  p_host_gate_r3: assert property (@(posedge clk) disable iff (rst)
    host_if_en == !on_battery);
  p_pulse_real_r8: assert property (@(posedge clk) disable iff (rst)
    (go_down || go_up) |=> (mode_change && on_battery != $past(on_battery)));
  p_pulse_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !(go_down || go_up) |=> !mode_change);
endmodule

// File: tb/test_pwr_switchover.sv
module test_pwr_switchover;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] vdd_mv = '0, bat_mv = '0;
  logic [31:0] now_time = '0;
  logic        status_rd = 1'b0;
  logic        on_battery, host_if_en, mode_change;
  logic [31:0] stamp_down, stamp_up;

  int total = 0, bad = 0;
  logic        m_bat = 0, m_held = 0, m_pulse = 0;
  logic [31:0] m_sd = 0, m_su = 0;

  always #2.5 clk = ~clk;

  pwr_switchover i_pwr_switchover (
    .clk(clk), .rst(rst), .vdd_mv(vdd_mv), .bat_mv(bat_mv),
    .now_time(now_time), .status_rd(status_rd), .on_battery(on_battery),
    .host_if_en(host_if_en), .mode_change(mode_change),
    .stamp_down(stamp_down), .stamp_up(stamp_up)
  );

  function automatic bit f_drop(int v, int b);
    int lo = (b > 50) ? b - 50 : 0;   // R7 saturation
    return (v < lo) && (v < 2200);
  endfunction

  function automatic bit f_rise(int v, int b);
    return (v > b + 50) || (v > 2230);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1/R2 on_battery", 32'(on_battery), 32'(m_bat));
    chk("R3 host_if_en", 32'(host_if_en), 32'(!m_bat));
    chk("R8 mode_change", 32'(mode_change), 32'(m_pulse));
    chk("R4 stamp_up", stamp_up, m_su);
    chk("R5/R6 stamp_down", stamp_down, m_sd);
  endtask

  // drive at negedge, update model, sample at the following negedge
  task automatic step(int v, int b, bit sr, int dt);
    logic eff;
    vdd_mv = 12'(v); bat_mv = 12'(b); status_rd = sr;
    now_time = now_time + 32'(dt);
    eff = m_held & ~sr;
    m_pulse = 0;
    if (!m_bat && f_drop(v, b)) begin
      m_bat = 1; m_pulse = 1;
      if (!eff) m_sd = now_time;
      m_held = 1;
    end else begin
      m_held = eff;
      if (m_bat && f_rise(v, b)) begin
        m_bat = 0; m_pulse = 1; m_su = now_time;
      end
    end
    @(posedge clk); @(negedge clk);
    check_all();
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 on_battery", 32'(on_battery), 0);
    chk("R9 host_if_en", 32'(host_if_en), 1);
    chk("R9 mode_change", 32'(mode_change), 0);
    chk("R9 stamp_down", stamp_down, 0);
    chk("R9 stamp_up", stamp_up, 0);
    rst = 1'b0;
    now_time = 32'd100;
    step(3300, 3000, 0, 1);   // healthy main
    step(0, 20, 0, 1);        // R7: limit saturates to 0, stays main
    step(0, 49, 0, 1);        // R7
    step(2000, 2050, 0, 1);   // R1 boundary: equal to bat-50, no switch
    step(2200, 3000, 0, 1);   // R1 boundary: equal to trip, no switch
    step(2199, 2300, 0, 3);   // R1: both conditions, to battery
    step(2230, 2500, 0, 2);   // R2 boundary: equal to trip+30, stays
    step(2099, 2049, 0, 2);   // R2 boundary: equal to bat+50, stays
    step(2100, 2049, 0, 5);   // R2: above bat+50, to main
    step(1000, 3000, 0, 4);   // R5: second outage, earliest stamp kept
    step(2231, 3000, 0, 6);   // R2: trip path, to main
    step(1000, 3000, 1, 7);   // R6: read coincides with outage, captured
    step(3000, 3000, 0, 1);   // R2 trip path back to main
    step(3000, 3000, 1, 1);   // R6: read while on main re-arms
    step(1500, 2500, 0, 9);   // R5: captured after re-arm
    for (int i = 0; i < 4000; i++) begin
      int b = $urandom_range(3600, 0);
      int v = ($urandom_range(3, 0) == 0) ? $urandom_range(4095, 0)
                                          : $urandom_range(2400, 1800);
      step(v, b, ($urandom_range(19, 0) == 0), $urandom_range(9, 1));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule